// File: doc/BRIEF.md
# NCO Bit-Rate Generator

This block produces the bit-rate timing for a serial port from a 16-bit phase increment. On every enabled system clock, a 16-bit phase accumulator adds the increment. Each carry out of the accumulator is one oversample tick, so the oversample rate is `increment * f_clk / 2^16`.

A divide-by-16 counter on the oversample ticks produces the bit tick. The bit rate is therefore `increment * f_clk / 2^20`, set by a register field rather than by an integer divisor. A second counter marks every tenth bit tick with a character strobe. That strobe paces one frame: a start bit, eight data bits and a stop bit.

A transmitter or receiver uses the three outputs as single-cycle enables. Dropping the enable clears all timing state, so the first bit after the enable rises is full length. An increment of zero parks the generator without error.

Top module: `nco_baud_top`

## Requirements
- R1: While reset is asserted, and after reset until the block is enabled, `ovsTick`, `bitTick` and `charDone` are low.
- R2: With enable high and increment N, `ovsTick` pulses on each cycle in which the running sum k*N, counted from zero, crosses a multiple of 65536. For example, N=0x1000 gives the first pulse on the 16th enabled edge and one every 16 edges after that. N=0x8000 gives one every 2 edges.
- R3: `bitTick` pulses together with every 16th `ovsTick`, so the bit rate is N*f/2^20. With N=0x1000 the first bit tick follows the 256th enabled edge, and 10 bit ticks occur in 2560 edges.
- R4: `charDone` pulses together with every 10th `bitTick`. With N=0x1000 the first one falls on the 2560th enabled edge.
- R5: `bitTick` and `charDone` are never high on two consecutive cycles, even at the largest increment 0xFFFF. `ovsTick` is high on every edge that produces a carry. With N=0xFFFF that is 319 of the first 320 edges, giving 19 bit ticks.
- R6: While enable is low, no output pulses and the accumulator and both counters are cleared. After enable rises again, the first oversample tick and the first bit tick come at full distance: 16 and 256 edges for N=0x1000.
- R7: An increment of zero produces no pulse on any output and holds all state. Loading a nonzero increment afterwards resumes ticking from the held state, with no lock-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator; low clears all timing state |
| increment | input | 16 | Phase increment added per clock |
| ovsTick | output | 1 | Oversample pulse, one per accumulator carry |
| bitTick | output | 1 | Bit-period pulse, every 16th oversample |
| charDone | output | 1 | Frame pulse, every 10th bit period |

## Verification
The bench measures the edge on which the first tick of each kind appears after enable, and counts ticks over fixed windows. Each increment is given in its own directed scenario: a medium one, one half scale, and the maximum where carries run back to back.

An accumulator that is not cleared on disable would give a short first bit after re-enable. An off-by-one divider would move the first bit tick away from edge 256 or the character strobe away from edge 2560.

A zero increment followed by a nonzero one exposes a design that locks up or ticks spuriously. The maximum increment catches a bit or character strobe that stretches over two cycles.

// File: rtl/nco_baud_pkg.sv
package nco_baud_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;   // zero accumulator and counters
    logic step;    // advance the accumulator this cycle
  } ncoCtrl_t;

endpackage

// File: rtl/nco_baud_ctrl.sv
module nco_baud_ctrl
  import nco_baud_pkg::*;
#(
  parameter int INC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [INC_W-1:0] increment,
  output ncoCtrl_t         strobes
);

  logic incNonZero;

  assign incNonZero    = |increment;
  assign strobes.clear = ~enable;
  assign strobes.step  = enable & incNonZero;

  // A zero increment must never advance the accumulator (R7)
  assert_zero_inc_no_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (increment == '0) |-> !strobes.step);

  // Disabled means clearing, never stepping (R6)
  assert_clear_excludes_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (strobes.clear && !strobes.step));

endmodule

// File: rtl/nco_baud_dp.sv
module nco_baud_dp
  import nco_baud_pkg::*;
#(
  parameter int ACC_W      = 16,
  parameter int OVS        = 16,
  parameter int FRAME_BITS = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  ncoCtrl_t         strobes,
  input  logic [ACC_W-1:0] increment,
  output logic             ovsTick,
  output logic             bitTick,
  output logic             charDone
);

  localparam int OVS_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int BIT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam logic [OVS_W-1:0] OVS_LAST = OVS_W'(OVS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

  logic [ACC_W-1:0] phase;
  logic [ACC_W:0]   phaseSum;
  logic [OVS_W-1:0] ovsCount;
  logic [BIT_W-1:0] bitCount;
  logic             carryEv;
  logic             bitEv;
  logic             charEv;

  assign phaseSum = {1'b0, phase} + {1'b0, increment};
  assign carryEv  = strobes.step & phaseSum[ACC_W];
  assign bitEv    = carryEv & (ovsCount == OVS_LAST);
  assign charEv   = bitEv & (bitCount == BIT_LAST);

  // Phase accumulator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
    end else if (strobes.clear) begin
      phase <= '0;
    end else if (strobes.step) begin
      phase <= phaseSum[ACC_W-1:0];
    end
  end

  // Oversample divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovsCount <= '0;
    end else if (strobes.clear) begin
      ovsCount <= '0;
    end else if (carryEv) begin
      ovsCount <= bitEv ? '0 : ovsCount + 1'b1;
    end
  end

  // Bits-per-frame counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
    end else if (strobes.clear) begin
      bitCount <= '0;
    end else if (bitEv) begin
      bitCount <= charEv ? '0 : bitCount + 1'b1;
    end
  end

  // Registered single-cycle outputs, all from the same stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovsTick  <= 1'b0;
      bitTick  <= 1'b0;
      charDone <= 1'b0;
    end else begin
      ovsTick  <= carryEv;
      bitTick  <= bitEv;
      charDone <= charEv;
    end
  end

  assert_clear_zeroes_state_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (phase == '0 && ovsCount == '0 && bitCount == '0));

  assert_hold_without_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.step && !strobes.clear) |=> ($stable(phase) && !ovsTick));

  assert_bit_with_ovs_R3: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> ovsTick);

  assert_char_with_bit_R4: assert property (@(posedge clk) disable iff (!rstN)
    charDone |-> bitTick);

  assert_bit_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |=> !bitTick);

  assert_char_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    charDone |=> !charDone);

endmodule

// File: rtl/nco_baud_top.sv
module nco_baud_top
  import nco_baud_pkg::*;
#(
  parameter int INC_W      = 16,
  parameter int OVS        = 16,
  parameter int FRAME_BITS = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [INC_W-1:0] increment,
  output logic             ovsTick,
  output logic             bitTick,
  output logic             charDone
);

  ncoCtrl_t strobes;

  nco_baud_ctrl #(.INC_W(INC_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .increment (increment),
    .strobes   (strobes)
  );

  nco_baud_dp #(.ACC_W(INC_W), .OVS(OVS), .FRAME_BITS(FRAME_BITS)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .increment (increment),
    .ovsTick   (ovsTick),
    .bitTick   (bitTick),
    .charDone  (charDone)
  );

  // Disabled generator stays silent (R6)
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!ovsTick && !bitTick && !charDone));

endmodule

// File: tb/nco_baud_top_tb_top.sv
module nco_baud_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] increment = '0;
  logic        ovsTick, bitTick, charDone;

  int nTests = 0;
  int nFail  = 0;

  int cyc, nOvs, nBit, nChar, firstOvs, firstBit, firstChar;
  int dblBit, dblChar;
  logic prevBit, prevChar;

  always #5 clk = ~clk;

  nco_baud_top dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .increment(increment),
    .ovsTick(ovsTick), .bitTick(bitTick), .charDone(charDone)
  );

  // Observer: one sample per cycle, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (ovsTick) begin nOvs++; if (firstOvs < 0) firstOvs = cyc; end
    if (bitTick) begin nBit++; if (firstBit < 0) firstBit = cyc; end
    if (charDone) begin nChar++; if (firstChar < 0) firstChar = cyc; end
    if (bitTick && prevBit) dblBit++;
    if (charDone && prevChar) dblChar++;
    prevBit = bitTick;
    prevChar = charDone;
  end

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Apply settings just after a sample and restart the window counters
  task automatic startWindow(input logic en, input logic [15:0] inc);
    @(negedge clk);
    #1;
    cyc = 0; nOvs = 0; nBit = 0; nChar = 0;
    firstOvs = -1; firstBit = -1; firstChar = -1;
    dblBit = 0; dblChar = 0; prevBit = 1'b0; prevChar = 1'b0;
    enable = en;
    increment = inc;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic testReset;
    waitCycles(3);
    checkEq("R1", "outputs in reset", {29'd0, ovsTick, bitTick, charDone}, 0);
    rstN = 1'b1;
    startWindow(1'b0, 16'h1000);
    waitCycles(20);
    checkEq("R1", "ticks after reset, not enabled", nOvs + nBit + nChar, 0);
  endtask

  task automatic testMedium;
    startWindow(1'b1, 16'h1000);
    waitCycles(2560);
    checkEq("R2", "first ovsTick edge", firstOvs, 16);
    checkEq("R2", "ovsTick count in 2560", nOvs, 160);
    checkEq("R3", "first bitTick edge", firstBit, 256);
    checkEq("R3", "bitTick count in 2560", nBit, 10);
    checkEq("R4", "first charDone edge", firstChar, 2560);
    checkEq("R4", "charDone count", nChar, 1);
  endtask

  task automatic testHalf;
    startWindow(1'b0, 16'h8000);
    waitCycles(2);
    startWindow(1'b1, 16'h8000);
    waitCycles(64);
    checkEq("R2", "half-scale first ovsTick", firstOvs, 2);
    checkEq("R2", "half-scale ovsTick count", nOvs, 32);
    checkEq("R3", "half-scale first bitTick", firstBit, 32);
  endtask

  task automatic testMax;
    startWindow(1'b0, 16'hFFFF);
    waitCycles(2);
    startWindow(1'b1, 16'hFFFF);
    waitCycles(320);
    checkEq("R5", "max ovsTick count", nOvs, 319);
    checkEq("R5", "max bitTick count", nBit, 19);
    checkEq("R5", "bitTick back to back", dblBit, 0);
    waitCycles(3000);
    checkEq("R5", "charDone back to back", dblChar, 0);
  endtask

  task automatic testDisable;
    startWindow(1'b1, 16'h1000);
    waitCycles(100);
    startWindow(1'b0, 16'h1000);
    waitCycles(50);
    checkEq("R6", "ticks while disabled", nOvs + nBit + nChar, 0);
    startWindow(1'b1, 16'h1000);
    waitCycles(300);
    checkEq("R6", "first ovsTick after re-enable", firstOvs, 16);
    checkEq("R6", "first bitTick after re-enable", firstBit, 256);
  endtask

  task automatic testZero;
    startWindow(1'b0, 16'h0000);
    waitCycles(2);
    startWindow(1'b1, 16'h0000);
    waitCycles(500);
    checkEq("R7", "ticks with zero increment", nOvs + nBit + nChar, 0);
    startWindow(1'b1, 16'h1000);
    waitCycles(300);
    checkEq("R7", "first ovsTick after zero", firstOvs, 16);
    checkEq("R7", "first bitTick after zero", firstBit, 256);
  endtask

  initial begin
    fork
      begin
        testReset();
        testMedium();
        testHalf();
        testMax();
        testDisable();
        testZero();
      end
      begin
        repeat (150000) @(posedge clk);
        nTests++;
        nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule